// File: doc/BRIEF.md
# Peripheral Power-Management Configuration Controller

This block holds one 32-bit configuration word for a peripheral and drives the power-management signals that the word controls. A power manager raises an idle request; the block answers with an idle acknowledge according to a programmed idle policy. The policies are: grant at once, never grant, or grant only while the peripheral reports no internal activity. Once idle has been granted, a clock-activity field selects whether the functional and interconnect clock enables drop. An auto-gating bit lets the interconnect clock enable follow traffic on the register port.

A write that sets the reset bit makes the block emit a one-cycle reset pulse to the peripheral. That bit is never stored and always reads as zero. The configuration word itself keeps its value through such a pulse. Only the hardware reset input clears it.

Top module: `pm_cfg_ctrl`

## Requirements
- R1: After reset, cfg_rdata is 0, idle_ack is 0, soft_rst is 0, and both ick_en and fck_en are 1.
- R2: Field positions: clock activity is at bits 9:8, idle policy is at bits 4:3, and auto-gating is at bit 0. A write stores these fields, and cfg_rdata shows them from the cycle after the write edge.
- R3: Every bit other than 9:8, 4:3 and 0 reads as 0 whatever was written to it. This includes reset bit 1.
- R4: A write with bit 1 set drives soft_rst high for exactly the one cycle after the write edge. A write with bit 1 clear produces no pulse. Either write updates the other fields normally.
- R5: Idle policy 0 (force): idle_ack is 1 in the cycle after idle_req is sampled high, regardless of mod_busy.
- R6: Idle policy 1 (never): idle_ack stays 0 while idle_req is held high.
- R7: Idle policy 2 (smart): idle_ack is 1 in the cycle after a sample with idle_req high and mod_busy low. It is 0 after any sample with mod_busy high.
- R8: Idle policy 3 reads back as 3 and behaves as policy 1.
- R9: idle_ack returns to 0 in the cycle after idle_req is sampled low.
- R10: While idle_ack is 1 and clock activity is 00, fck_en and ick_en are both 0. Both return to 1 in the same cycle in which idle_ack falls.
- R11: While idle_ack is 1 and clock activity is non-zero, fck_en stays 1, and ick_en follows only the auto-gating rule.
- R12: With auto-gating 0, ick_en is 1 outside the idle-gated state. With auto-gating 1, ick_en equals (cfg_wr OR cfg_rd) outside the idle-gated state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe (counts as port activity) |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Current register contents |
| idle_req | input | 1 | Idle request from the power manager |
| mod_busy | input | 1 | Peripheral internal activity |
| idle_ack | output | 1 | Idle acknowledge |
| soft_rst | output | 1 | One-cycle peripheral reset pulse |
| ick_en | output | 1 | Interconnect clock enable |
| fck_en | output | 1 | Functional clock enable |

## Verification
A wrong stored policy does not stay hidden: it shows at idle_ack on the first edge after a request, as either a grant that should not happen or a grant that is missing. A corrupted clock-activity or auto-gating field shows at the same time, on the clock enables during idle or during port silence. A latched reset bit appears on soft_rst one cycle later as a pulse that lasts too long, and on cfg_rdata bit 1 at once.

// File: rtl/pm_cfg_pkg.sv
package pm_cfg_pkg;
    localparam int REG_W     = 32;
    localparam int AUTO_BIT  = 0;
    localparam int SRST_BIT  = 1;
    localparam int POL_LO    = 3;
    localparam int CACT_LO   = 8;
    localparam int FIELD_W   = 2;

    typedef enum logic [FIELD_W-1:0] {
        POL_FORCE = 2'd0,
        POL_NEVER = 2'd1,
        POL_SMART = 2'd2,
        POL_RSVD  = 2'd3
    } idle_pol_e;

    typedef struct packed {
        logic [FIELD_W-1:0] cact;
        idle_pol_e          pol;
        logic               auto_gate;
        logic               srst;
    } cfg_state_t;

    typedef struct packed {
        logic ack;
    } idle_state_t;
endpackage

// File: rtl/pm_cfg_regs.sv
module pm_cfg_regs
    import pm_cfg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic [REG_W-1:0]     cfg_wdata,
    output logic [REG_W-1:0]     cfg_rdata,
    output logic [FIELD_W-1:0]   cact,
    output idle_pol_e            pol,
    output logic                 auto_gate,
    output logic                 soft_rst
);
    cfg_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.srst = 1'b0;
        if (cfg_wr) begin
            st_d.cact      = cfg_wdata[CACT_LO +: FIELD_W];
            st_d.pol       = idle_pol_e'(cfg_wdata[POL_LO +: FIELD_W]);
            st_d.auto_gate = cfg_wdata[AUTO_BIT];
            st_d.srst      = cfg_wdata[SRST_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        cfg_rdata                       = '0;
        cfg_rdata[CACT_LO +: FIELD_W]   = st_q.cact;
        cfg_rdata[POL_LO +: FIELD_W]    = st_q.pol;
        cfg_rdata[AUTO_BIT]             = st_q.auto_gate;
    end

    assign cact      = st_q.cact;
    assign pol       = st_q.pol;
    assign auto_gate = st_q.auto_gate;
    assign soft_rst  = st_q.srst;

    // R4
    srst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_wdata[SRST_BIT]) |=> soft_rst);
    // R4
    srst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |-> $past(cfg_wr && cfg_wdata[SRST_BIT]));
    // R2
    pol_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (cfg_rdata[POL_LO +: FIELD_W] == $past(cfg_wdata[POL_LO +: FIELD_W])));
endmodule

// File: rtl/pm_idle_ctrl.sv
module pm_idle_ctrl
    import pm_cfg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  idle_pol_e pol,
    input  logic      idle_req,
    input  logic      mod_busy,
    output logic      idle_ack
);
    idle_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!idle_req) begin
            st_d.ack = 1'b0;
        end else begin
            unique case (pol)
                POL_FORCE: st_d.ack = 1'b1;
                POL_SMART: st_d.ack = !mod_busy;
                default:   st_d.ack = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign idle_ack = st_q.ack;

    // R5
    force_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_req && pol == POL_FORCE) |=> idle_ack);
    // R6
    never_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pol == POL_NEVER || pol == POL_RSVD) |=> !idle_ack);
    // R7
    smart_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pol == POL_SMART && mod_busy) |=> !idle_ack);
    // R9
    ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !idle_req |=> !idle_ack);
endmodule

// File: rtl/pm_clk_gate.sv
module pm_clk_gate
    import pm_cfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               idle_ack,
    input  logic [FIELD_W-1:0] cact,
    input  logic               auto_gate,
    input  logic               port_active,
    output logic               ick_en,
    output logic               fck_en
);
    logic idle_gated;

    always_comb begin
        idle_gated = idle_ack && (cact == '0);
        fck_en     = !idle_gated;
        ick_en     = !idle_gated && (!auto_gate || port_active);
    end

    // R10
    fck_off_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fck_en |-> idle_ack);
    // R12
    ick_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle_ack && !auto_gate) |-> ick_en);
endmodule

// File: rtl/pm_cfg_ctrl.sv
module pm_cfg_ctrl
    import pm_cfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             cfg_rd,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    input  logic             idle_req,
    input  logic             mod_busy,
    output logic             idle_ack,
    output logic             soft_rst,
    output logic             ick_en,
    output logic             fck_en
);
    logic [FIELD_W-1:0] cact;
    idle_pol_e          pol;
    logic               auto_gate;

    pm_cfg_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .cact      (cact),
        .pol       (pol),
        .auto_gate (auto_gate),
        .soft_rst  (soft_rst)
    );

    pm_idle_ctrl u_idle (
        .clk      (clk),
        .rst_n    (rst_n),
        .pol      (pol),
        .idle_req (idle_req),
        .mod_busy (mod_busy),
        .idle_ack (idle_ack)
    );

    pm_clk_gate u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .idle_ack    (idle_ack),
        .cact        (cact),
        .auto_gate   (auto_gate),
        .port_active (cfg_wr || cfg_rd),
        .ick_en      (ick_en),
        .fck_en      (fck_en)
    );

    // R9
    ack_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle_ack |-> $past(idle_req));
endmodule

// File: tb/pm_cfg_ctrl_bench.sv
module pm_cfg_ctrl_bench;
    localparam int PER = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        idle_req = 1'b0, mod_busy = 1'b0;
    logic        idle_ack, soft_rst, ick_en, fck_en;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    localparam int S_RD = 0, S_ACK = 1, S_SRST = 2, S_ICK = 3, S_FCK = 4;

    typedef struct {
        int          at;
        int          sig;
        logic [31:0] val;
        string       req;
    } exp_t;
    exp_t sb[$];

    pm_cfg_ctrl u_pm_cfg_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .idle_req(idle_req),
        .mod_busy(mod_busy), .idle_ack(idle_ack), .soft_rst(soft_rst),
        .ick_en(ick_en), .fck_en(fck_en)
    );

    always #(PER/2) clk = ~clk;

    function automatic logic [31:0] pick(int sig);
        case (sig)
            S_RD:    return cfg_rdata;
            S_ACK:   return {31'b0, idle_ack};
            S_SRST:  return {31'b0, soft_rst};
            S_ICK:   return {31'b0, ick_en};
            default: return {31'b0, fck_en};
        endcase
    endfunction

    // monitor: pops expectations due in this cycle
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            #(PER/4);
            while (sb.size() > 0 && sb[0].at <= cyc) begin
                exp_t e;
                logic [31:0] got;
                e = sb.pop_front();
                got = pick(e.sig);
                total++;
                if (e.at != cyc || got !== e.val) begin
                    bad++;
                    $display("FAIL %s sig=%0d got=%h exp=%h", e.req, e.sig, got, e.val);
                end
            end
        end
    end

    task automatic drive(input logic wr, input logic rd, input logic [31:0] wd,
                         input logic req, input logic busy);
        @(negedge clk);
        cfg_wr = wr; cfg_rd = rd; cfg_wdata = wd; idle_req = req; mod_busy = busy;
    endtask

    task automatic expect_next(input int sig, input logic [31:0] v, input string r);
        sb.push_back('{cyc + 1, sig, v, r});
    endtask

    initial begin
        #(PER * 20000);
        bad++;
        total++;
        $display("FAIL watchdog expired got=hung exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1 reset state
        drive(0, 0, 32'h0, 0, 0);
        expect_next(S_RD, 32'h0, "R1"); expect_next(S_ACK, 0, "R1");
        expect_next(S_SRST, 0, "R1"); expect_next(S_ICK, 1, "R1");
        expect_next(S_FCK, 1, "R1");
        @(negedge clk); rst_n = 1'b1;
        // R2 R3: all ones written, only real fields survive
        drive(1, 0, 32'hFFFF_FFFF, 0, 0);
        expect_next(S_RD, 32'h0000_0319, "R3"); expect_next(S_SRST, 1, "R4");
        drive(0, 0, 32'h0, 0, 0);
        expect_next(S_SRST, 0, "R4"); expect_next(S_ICK, 0, "R12");
        expect_next(S_FCK, 1, "R12");
        drive(0, 1, 32'h0, 0, 0);
        expect_next(S_ICK, 1, "R12");
        // R4 reset bit alone
        drive(1, 0, 32'h0000_0002, 0, 0);
        expect_next(S_RD, 32'h0, "R4"); expect_next(S_SRST, 1, "R4");
        drive(0, 0, 32'h0, 0, 0);
        expect_next(S_SRST, 0, "R4"); expect_next(S_ICK, 1, "R12");
        drive(1, 0, 32'h0, 0, 0);
        expect_next(S_SRST, 0, "R4"); expect_next(S_RD, 32'h0, "R2");
        // R5 force policy, clock activity 00
        drive(0, 0, 32'h0, 1, 1);
        expect_next(S_ACK, 1, "R5"); expect_next(S_FCK, 0, "R10");
        expect_next(S_ICK, 0, "R10");
        drive(0, 0, 32'h0, 0, 1);
        expect_next(S_ACK, 0, "R9"); expect_next(S_FCK, 1, "R10");
        expect_next(S_ICK, 1, "R10");
        // R6 never policy
        drive(1, 0, 32'h0000_0008, 0, 0);
        expect_next(S_RD, 32'h0000_0008, "R2");
        drive(0, 0, 32'h0, 1, 0);
        expect_next(S_ACK, 0, "R6");
        drive(0, 0, 32'h0, 1, 0);
        expect_next(S_ACK, 0, "R6");
        // R7 smart policy
        drive(1, 0, 32'h0000_0010, 1, 1);
        expect_next(S_RD, 32'h0000_0010, "R2"); expect_next(S_ACK, 0, "R6");
        drive(0, 0, 32'h0, 1, 1);
        expect_next(S_ACK, 0, "R7");
        drive(0, 0, 32'h0, 1, 0);
        expect_next(S_ACK, 1, "R7"); expect_next(S_FCK, 0, "R10");
        drive(0, 0, 32'h0, 1, 1);
        expect_next(S_ACK, 0, "R7");
        drive(0, 0, 32'h0, 0, 0);
        expect_next(S_ACK, 0, "R9");
        // R8 reserved policy
        drive(1, 0, 32'h0000_0018, 0, 0);
        expect_next(S_RD, 32'h0000_0018, "R8");
        drive(0, 0, 32'h0, 1, 0);
        expect_next(S_ACK, 0, "R8");
        drive(0, 0, 32'h0, 1, 0);
        expect_next(S_ACK, 0, "R8");
        // R11 clock activity non-zero, force policy
        drive(1, 0, 32'h0000_0100, 1, 0);
        expect_next(S_RD, 32'h0000_0100, "R2"); expect_next(S_ACK, 0, "R8");
        drive(0, 0, 32'h0, 1, 1);
        expect_next(S_ACK, 1, "R5"); expect_next(S_FCK, 1, "R11");
        expect_next(S_ICK, 1, "R11");
        // R11 with auto-gating on during idle
        drive(1, 0, 32'h0000_0101, 1, 1);
        expect_next(S_ACK, 1, "R5"); expect_next(S_ICK, 1, "R12");
        drive(0, 0, 32'h0, 1, 1);
        expect_next(S_ACK, 1, "R5"); expect_next(S_ICK, 0, "R11");
        expect_next(S_FCK, 1, "R11");
        drive(0, 0, 32'h0, 0, 0);
        expect_next(S_ACK, 0, "R9");
        drive(0, 0, 32'h0, 0, 0);
        drive(0, 0, 32'h0, 0, 0);
        if (sb.size() != 0) begin
            bad++; total++;
            $display("FAIL scoreboard got=%0d exp=0 pending", sb.size());
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule